// File: doc/BRIEF.md
# Bad-Block Marker Scanner

This block walks a span of erase blocks on a raw NAND device and records, for each block, whether the factory bad-block marker is present. For every block in the span it asks a separate page-read requester for the spare bytes of the block's first page. It then judges those bytes against the marker rule for the configured page size and bus width, and writes a good or bad flag into an internal table. Each table entry holds two bits and reads as unknown until a scan has visited that block.

Software, or a sequencer above this block, gives the first and last block as two's-complement values, along with the device block count, pages per block, page size and bus width, and then pulses `start`. Bounds that fall outside the device are clamped rather than rejected. A failing page read stops the scan at once and raises the error flag. When the walk ends, `done` pulses for one cycle. The table has a registered query port that can be read at any time.

Top module: `blkmark_scan`

## Requirements
- R1: For each scanned block exactly one page read is requested, `rd_req` is high for one cycle, and `rd_page` equals block index × `pages_per_blk`. Blocks are visited in ascending order, so successive requests of a scan differ by `pages_per_blk`.
- R2: When `bus16` is 1, a block is bad if spare byte 0 ANDed with spare byte 1 differs from 0xFF. Spare byte k arrives on `rd_spare[8k+7:8k]`, k = 0..5. This condition is ORed with the page-size rule.
- R3: When `big_page` is 0 (512-byte pages), a block is bad if spare byte 5 differs from 0xFF.
- R4: When `big_page` is 1 (2048-byte pages), a block is bad if spare byte 0 differs from 0xFF.
- R5: A `first_blk` that is negative (its top bit is set) or not below `num_blocks` is replaced by 0.
- R6: A `last_blk` equal to -1 (all ones), or non-negative and not below `num_blocks`, is replaced by `num_blocks`-1.
- R7: If the clamped last block is below the clamped first block, or `last_blk` is negative but not -1, no read is requested and `done` still pulses.
- R8: A read response with `rd_err` high ends the scan at once. `err` becomes 1 in the cycle `done` pulses, no further read is requested, and the failing block's entry keeps its previous value. Earlier blocks keep their new flags.
- R9: Table entries are 00 = unknown, 01 = good and 10 = bad. All entries read unknown after reset, a scan writes only good or bad, and entries outside the scanned span are left untouched.
- R10: `done` is high for exactly one cycle per accepted `start`. `err` is cleared when a new scan is accepted.
- R11: `q_flag` shows the entry selected by `q_idx` one clock after `q_idx` is applied.
- R12: A `start` pulse that arrives while a scan is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin a scan (accepted only when idle) |
| first_blk | input | BLK_W+1 | First block, two's complement |
| last_blk | input | BLK_W+1 | Last block, two's complement (-1 means last in device) |
| num_blocks | input | BLK_W+1 | Number of blocks on the device |
| pages_per_blk | input | PPB_W | Pages per erase block |
| big_page | input | 1 | 0: 512-byte pages, 1: 2048-byte pages |
| bus16 | input | 1 | 1: 16-bit device bus |
| rd_req | output | 1 | One-cycle page-read request |
| rd_page | output | BLK_W+PPB_W | Page number of the request |
| rd_valid | input | 1 | Read response strobe |
| rd_err | input | 1 | Read failed (qualified by `rd_valid`) |
| rd_spare | input | 48 | Six spare bytes, byte k at bits 8k+7:8k |
| done | output | 1 | One-cycle end-of-scan pulse |
| err | output | 1 | Last scan aborted by a read failure |
| q_idx | input | BLK_W | Table query index |
| q_flag | output | 2 | Queried flag, registered |

## Verification
A wrong block counter or page accumulator shows up at the very first or second `rd_page` of a scan, as a page that is not a multiple of `pages_per_blk` or that skips a step. A wrong clamp decision shows up before the first request, as a missing or misplaced request or as table entries changing outside the span. A fault in the marker judge or in the table write path shows up only when the table is read back after `done`, so the bench reads every entry after every scan, under all four bus-width and page-size combinations. A stuck state machine shows up as a missing or doubled `done` pulse, or as an `err` level that disagrees with the injected read failure.

// File: rtl/blkmark_pkg.sv
package blkmark_pkg;

  localparam int SPARE_BYTES = 6;
  localparam int SPARE_W     = SPARE_BYTES * 8;

  typedef enum logic [1:0] {
    FLAG_UNKNOWN = 2'b00,
    FLAG_GOOD    = 2'b01,
    FLAG_BAD     = 2'b10
  } blk_flag_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_EVAL,
    ST_NEXT,
    ST_DONE
  } scan_state_e;

endpackage

// File: rtl/blkmark_range.sv
module blkmark_range #(
  parameter  int MAX_BLOCKS = 1024,
  localparam int BLK_W      = $clog2(MAX_BLOCKS),
  localparam int SW         = BLK_W + 1
) (
  input  logic [SW-1:0]    first_i,
  input  logic [SW-1:0]    last_i,
  input  logic [SW-1:0]    num_i,
  output logic [BLK_W-1:0] first_o,
  output logic [BLK_W-1:0] last_o,
  output logic             empty_o
);

  logic [SW-1:0] num_eff;
  logic [SW-1:0] first_c;
  logic [SW-1:0] last_c;
  logic          f_neg, f_past, l_neg, l_m1, l_past;

  always_comb begin
    num_eff = (num_i > SW'(MAX_BLOCKS)) ? SW'(MAX_BLOCKS) : num_i;
    f_neg   = first_i[SW-1];
    l_neg   = last_i[SW-1];
    l_m1    = (last_i == {SW{1'b1}});
    f_past  = !f_neg && (first_i >= num_eff);
    l_past  = !l_neg && (last_i >= num_eff);
    first_c = (f_neg || f_past) ? '0 : first_i;
    last_c  = (l_m1 || l_past) ? (num_eff - SW'(1)) : last_i;
    empty_o = (num_eff == '0) || (l_neg && !l_m1) || (last_c < first_c);
    first_o = first_c[BLK_W-1:0];
    last_o  = last_c[BLK_W-1:0];
  end

endmodule

// File: rtl/blkmark_judge.sv
module blkmark_judge
  import blkmark_pkg::*;
(
  input  logic [SPARE_W-1:0] spare_i,
  input  logic               bus16_i,
  input  logic               big_page_i,
  output logic               bad_o
);

  logic [7:0] sb [SPARE_BYTES];

  for (genvar k = 0; k < SPARE_BYTES; k++) begin : g_bytes
    assign sb[k] = spare_i[8*k +: 8];
  end

  logic wide_bad, small_bad, large_bad;

  always_comb begin
    wide_bad  = bus16_i && ((sb[0] & sb[1]) != 8'hFF);
    small_bad = !big_page_i && (sb[5] != 8'hFF);
    large_bad = big_page_i && (sb[0] != 8'hFF);
    bad_o     = wide_bad || small_bad || large_bad;
  end

endmodule

// File: rtl/blkmark_table.sv
module blkmark_table
  import blkmark_pkg::*;
#(
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [1:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [1:0]    rdata
);

  logic [1:0] flags_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) flags_q[i] <= FLAG_UNKNOWN;
    end else if (we) begin
      flags_q[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= FLAG_UNKNOWN;
    else        rdata <= flags_q[raddr];
  end

  AST_WR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (wdata == FLAG_GOOD || wdata == FLAG_BAD)); // R9

endmodule

// File: rtl/blkmark_scan.sv
module blkmark_scan
  import blkmark_pkg::*;
#(
  parameter  int MAX_BLOCKS = 1024,
  parameter  int PPB_W      = 8,
  localparam int BLK_W      = $clog2(MAX_BLOCKS),
  localparam int SW         = BLK_W + 1,
  localparam int PAGE_W     = BLK_W + PPB_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SW-1:0]      first_blk,
  input  logic [SW-1:0]      last_blk,
  input  logic [SW-1:0]      num_blocks,
  input  logic [PPB_W-1:0]   pages_per_blk,
  input  logic               big_page,
  input  logic               bus16,
  output logic               rd_req,
  output logic [PAGE_W-1:0]  rd_page,
  input  logic               rd_valid,
  input  logic               rd_err,
  input  logic [SPARE_W-1:0] rd_spare,
  output logic               done,
  output logic               err,
  input  logic [BLK_W-1:0]   q_idx,
  output logic [1:0]         q_flag
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  // Bound clamping
  logic [BLK_W-1:0] rng_first, rng_last;
  logic             rng_empty;

  blkmark_range #(.MAX_BLOCKS(MAX_BLOCKS)) u_range (
    .first_i (first_blk),
    .last_i  (last_blk),
    .num_i   (num_blocks),
    .first_o (rng_first),
    .last_o  (rng_last),
    .empty_o (rng_empty)
  );

  // Scan state
  scan_state_e        state_q, state_d;
  logic [BLK_W-1:0]   cur_q, cur_d;
  logic [BLK_W-1:0]   last_q, last_d;
  logic [PAGE_W-1:0]  page_q, page_d;
  logic               err_q, err_d;
  logic [SPARE_W-1:0] spare_q;
  logic               spare_en;

  always_comb begin
    state_d  = state_q;
    cur_d    = cur_q;
    last_d   = last_q;
    page_d   = page_q;
    err_d    = err_q;
    spare_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          err_d   = 1'b0;
          cur_d   = rng_first;
          last_d  = rng_last;
          page_d  = PAGE_W'(rng_first) * PAGE_W'(pages_per_blk);
          state_d = rng_empty ? ST_DONE : ST_ISSUE;
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (rd_valid) begin
          if (rd_err) begin
            err_d   = 1'b1;
            state_d = ST_DONE;
          end else begin
            spare_en = 1'b1;
            state_d  = ST_EVAL;
          end
        end
      end
      ST_EVAL: state_d = ST_NEXT;
      ST_NEXT: begin
        if (cur_q == last_q) begin
          state_d = ST_DONE;
        end else begin
          cur_d   = cur_q + BLK_W'(1);
          page_d  = page_q + PAGE_W'(pages_per_blk);
          state_d = ST_ISSUE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      last_q  <= '0;
      page_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      last_q  <= last_d;
      page_q  <= page_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (spare_en) spare_q <= rd_spare;
  end

  // Marker decision and flag table
  logic blk_bad;

  blkmark_judge u_judge (
    .spare_i    (spare_q),
    .bus16_i    (bus16),
    .big_page_i (big_page),
    .bad_o      (blk_bad)
  );

  blkmark_table #(.DEPTH(MAX_BLOCKS)) u_table (
    .clk   (clk),
    .rst_n (rst_s_n),
    .we    (state_q == ST_EVAL),
    .waddr (cur_q),
    .wdata (blk_bad ? FLAG_BAD : FLAG_GOOD),
    .raddr (q_idx),
    .rdata (q_flag)
  );

  assign rd_req  = (state_q == ST_ISSUE);
  assign rd_page = page_q;
  assign done    = (state_q == ST_DONE);
  assign err     = err_q;

  // Checker state: page of the previous request within the current scan
  logic [PAGE_W-1:0] prev_page_q;
  logic              req_seen_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      prev_page_q <= '0;
      req_seen_q  <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      req_seen_q  <= 1'b0;
    end else if (rd_req) begin
      prev_page_q <= rd_page;
      req_seen_q  <= 1'b1;
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    rd_req |=> !rd_req); // R1
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_req && req_seen_q) |-> (rd_page == prev_page_q + PAGE_W'(pages_per_blk))); // R1
  AST_CUR_BOUND: assert property (@(posedge clk) disable iff (!rst_s_n)
    rd_req |-> (cur_q <= last_q)); // R6
  AST_NO_REQ_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_s_n)
    err |-> !rd_req); // R8
  AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(err) |-> done); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> !done); // R10

endmodule

// File: tb/blkmark_scan_test.sv
`timescale 1ns/1ps
module blkmark_scan_test;

  localparam int MAXB   = 16;
  localparam int PPBW   = 8;
  localparam int SW     = 5;
  localparam int PAGEW  = 12;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [SW-1:0]     first_blk, last_blk, num_blocks;
  logic [PPBW-1:0]   pages_per_blk;
  logic              big_page, bus16;
  logic              rd_req;
  logic [PAGEW-1:0]  rd_page;
  logic              rd_valid, rd_err;
  logic [47:0]       rd_spare;
  logic              done, err;
  logic [3:0]        q_idx;
  logic [1:0]        q_flag;

  blkmark_scan #(.MAX_BLOCKS(MAXB), .PPB_W(PPBW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .first_blk(first_blk), .last_blk(last_blk), .num_blocks(num_blocks),
    .pages_per_blk(pages_per_blk), .big_page(big_page), .bus16(bus16),
    .rd_req(rd_req), .rd_page(rd_page), .rd_valid(rd_valid), .rd_err(rd_err),
    .rd_spare(rd_spare), .done(done), .err(err), .q_idx(q_idx), .q_flag(q_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Read responder and request monitor
  logic [47:0] spare_mem [MAXB];
  int model [MAXB];
  int err_blk   = -1;
  int lat       = 0;
  int ppb       = 4;
  int exp_next  = 0;
  int n_req     = 0;
  int mism      = 0;
  int pend      = 0;
  int cnt       = 0;
  int pblk      = 0;

  always @(negedge clk) begin
    if (rd_valid) begin
      rd_valid = 1'b0;
      rd_err   = 1'b0;
    end
    if (pend != 0) begin
      if (cnt == 0) begin
        rd_valid = 1'b1;
        rd_err   = (pblk == err_blk);
        rd_spare = spare_mem[pblk % MAXB];
        pend     = 0;
      end else cnt--;
    end
    if (rd_req === 1'b1) begin
      n_req++;
      if ((int'(rd_page) % ppb) != 0 || (int'(rd_page) / ppb) != exp_next) mism++;
      pblk = int'(rd_page) / ppb;
      exp_next++;
      pend = 1;
      cnt  = lat;
    end
  end

  function automatic logic [47:0] pattern(input int blk, input int seed);
    logic [47:0] p;
    p = 48'hFFFF_FFFF_FFFF;
    case ((blk + seed) % 8)
      1: p[7:0] = 8'h00;
      2: p[15:8] = 8'hFE;
      3: p[47:40] = 8'h7F;
      4: begin p[7:0] = 8'hF0; p[15:8] = 8'h0F; end
      5: p[23:16] = 8'h00;
      6: begin p[39:32] = 8'h00; p[31:24] = 8'h11; end
      7: begin p[7:0] = 8'hFE; p[47:40] = 8'h00; end
      default: ;
    endcase
    return p;
  endfunction

  // Expected flag from the marker rules (1 = good, 2 = bad)
  function automatic int exp_flag(input logic [47:0] p, input bit b16, input bit big);
    bit bad;
    bad = 1'b0;
    if (b16 && ((p[7:0] & p[15:8]) != 8'hFF)) bad = 1'b1;
    if (!big && (p[47:40] != 8'hFF)) bad = 1'b1;
    if (big && (p[7:0] != 8'hFF)) bad = 1'b1;
    return bad ? 2 : 1;
  endfunction

  task automatic read_table(input string span_tag, input int lo, input int hi);
    for (int i = 0; i < MAXB; i++) begin
      q_idx = 4'(i);
      @(negedge clk);
      chk(int'(q_flag) == model[i], (i >= lo && i <= hi) ? span_tag : "R9",
          $sformatf("table entry %0d", i), q_flag, model[i]);
    end
  endtask

  task automatic scan(input int f, input int l, input int num, input int pp,
                      input bit big, input bit b16, input int eb, input int la,
                      input int seed, input bit mid_start, input string tag);
    int ef, el, nexp, wr_hi, k, req0, extra;
    bit empty, exp_err;
    for (int i = 0; i < MAXB; i++) spare_mem[i] = pattern(i, seed);
    ef = (f < 0 || f >= num) ? 0 : f;
    el = (l == -1 || l >= num) ? num - 1 : l;
    empty = (l < -1) || (el < ef);
    exp_err = !empty && eb >= ef && eb <= el;
    nexp = empty ? 0 : (exp_err ? eb - ef + 1 : el - ef + 1);
    wr_hi = exp_err ? eb - 1 : el;
    err_blk = eb; lat = la; ppb = pp;
    exp_next = ef; n_req = 0; mism = 0;
    first_blk = SW'(f); last_blk = SW'(l); num_blocks = SW'(num);
    pages_per_blk = PPBW'(pp); big_page = big; bus16 = b16;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < 3000) begin
      if (mid_start && k == 3) begin
        start = 1'b1; first_blk = SW'(0); last_blk = SW'(0);
      end
      if (mid_start && k == 4) start = 1'b0;
      @(negedge clk);
      k++;
    end
    chk(done == 1'b1, "R10", "done pulse seen", done, 1);
    chk(err == exp_err, exp_err ? "R8" : "R10", "err at done", err, exp_err);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done one cycle", done, 0);
    req0 = n_req; extra = 0;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk(extra == 0 && n_req == req0, "R12", "no restart after done", extra + n_req - req0, 0);
    chk(n_req == nexp, empty ? "R7" : tag, "request count", n_req, nexp);
    chk(mism == 0, "R1", "request page sequence", mism, 0);
    if (!empty)
      for (int i = ef; i <= wr_hi; i++) model[i] = exp_flag(spare_mem[i], b16, big);
    read_table(tag, ef, wr_hi);
  endtask

  // Watchdog
  initial begin
    wait (cycles > 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int a, b;
    rst_n = 1'b0; start = 1'b0; rd_valid = 1'b0; rd_err = 1'b0; rd_spare = '0;
    first_blk = '0; last_blk = '0; num_blocks = SW'(MAXB); pages_per_blk = 8'd4;
    big_page = 1'b0; bus16 = 1'b0; q_idx = '0;
    for (int i = 0; i < MAXB; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rd_req == 1'b0, "R1", "reset rd_req", rd_req, 0);
    chk(done == 1'b0, "R10", "reset done", done, 0);
    chk(err == 1'b0, "R8", "reset err", err, 0);
    read_table("R9", 0, -1);

    // Full sweep under each bus width and page size
    scan(0, 15, 16, 4, 1'b0, 1'b0, -1, 0, 0, 1'b0, "R3");
    scan(0, 15, 16, 4, 1'b1, 1'b0, -1, 1, 1, 1'b0, "R4");
    scan(0, 15, 16, 4, 1'b0, 1'b1, -1, 2, 2, 1'b0, "R2");
    scan(0, 15, 16, 4, 1'b1, 1'b1, -1, 0, 3, 1'b0, "R2");
    // Clamping
    scan(-3, 5, 16, 4, 1'b1, 1'b0, -1, 0, 5, 1'b0, "R5");
    scan(13, 3, 12, 4, 1'b0, 1'b0, -1, 1, 6, 1'b0, "R5");
    scan(10, -1, 12, 4, 1'b0, 1'b1, -1, 0, 7, 1'b0, "R6");
    scan(2, 15, 12, 4, 1'b1, 1'b0, -1, 0, 4, 1'b0, "R6");
    // Empty spans
    scan(5, -2, 16, 4, 1'b0, 1'b0, -1, 0, 1, 1'b0, "R7");
    scan(9, 4, 16, 4, 1'b0, 1'b0, -1, 0, 2, 1'b0, "R7");
    // Read failures, then recovery
    scan(0, 15, 16, 4, 1'b0, 1'b0, 6, 1, 3, 1'b0, "R8");
    scan(4, 9, 16, 4, 1'b1, 1'b1, 4, 0, 0, 1'b0, "R8");
    scan(0, 15, 16, 4, 1'b1, 1'b0, -1, 0, 2, 1'b0, "R10");
    // Other block sizes
    scan(3, 7, 16, 64, 1'b0, 1'b0, -1, 0, 5, 1'b0, "R1");
    scan(14, 15, 16, 255, 1'b1, 1'b1, -1, 3, 6, 1'b0, "R1");
    // Start during a running scan
    scan(1, 12, 16, 8, 1'b0, 1'b1, -1, 2, 7, 1'b1, "R12");

    // Query latency
    a = -1; b = -1;
    for (int i = 1; i < MAXB; i++) if (a < 0 && model[i] != model[0]) begin a = 0; b = i; end
    if (a >= 0) begin
      q_idx = 4'(a);
      @(negedge clk);
      q_idx = 4'(b);
      #1;
      chk(int'(q_flag) == model[a], "R11", "flag before clock", q_flag, model[a]);
      @(negedge clk);
      chk(int'(q_flag) == model[b], "R11", "flag after clock", q_flag, model[b]);
    end else begin
      chk(1'b0, "R11", "no differing entries", 0, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule